// File: doc/BRIEF.md
# Compressed-Audio Burst Sync Detector

This block sits behind a stereo digital audio receiver and watches the 16-bit words it delivers. The receiver presents one word per subframe, marked by `word_valid`, and a one-clock `frame_strobe` once per stereo frame. The detector looks for the fixed six-word sync sequence that opens a compressed (non-PCM) data burst. When it sees that sequence, it raises a sticky `detected` flag and captures the two burst-info words that follow, Pc and then Pd.

The flag stays high until 4096 frame strobes have passed with no new sync. Every new sync restarts that window. Downstream logic uses the flag to mute or reroute the PCM path. It reads the captured Pc and Pd to learn the burst type and length. The `capture_valid` pulse marks each update of those two registers.

Three state machines make up the design:

- **Matcher.** States `M_IDLE`, `M_Z1`, `M_Z2`, `M_Z3`, `M_Z4` and `M_MARK_A`.
  - Each valid zero word steps from `M_IDLE` through `M_Z1`, `M_Z2` and `M_Z3` to `M_Z4`.
  - Further zeros keep it in `M_Z4`.
  - 0xF872 moves it from `M_Z4` to `M_MARK_A`.
  - 0x4E1F in `M_MARK_A` fires the sync hit and returns to `M_IDLE`.
  - Any other word returns to `M_IDLE`, or to `M_Z1` if that word is zero.
- **Hold timer.** States `T_IDLE` and `T_HOLD`.
  - A sync hit enters or re-enters `T_HOLD`.
  - The 4096th strobe with no hit returns to `T_IDLE`.
- **Capture unit.** States `C_WAIT`, `C_PC` and `C_PD`.
  - A sync hit moves it to `C_PC`.
  - A valid word moves it from `C_PC` to `C_PD`.
  - A valid word in `C_PD` completes the capture and returns to `C_WAIT`.
  - A sync hit in any state restarts at `C_PC`.

Top module: `burst_sync_detector`

## Requirements
- R1: While `rst` is high at a clock edge, `detected`, `capture_valid`, `burst_info_c` and `burst_info_d` are all 0 after that edge, and matching and capture restart from their idle states.
- R2: When the valid words 0x0000, 0x0000, 0x0000, 0x0000, 0xF872 and 0x4E1F arrive in that order, `detected` is 1 after the clock edge that accepts the final 0x4E1F.
- R3: A sequence that is incomplete or wrong (too few zeros, or a wrong word in any position) never sets `detected`.
- R4: The matcher handles zeros in two ways. After four zeros, additional zero words keep the zero run matched, so a sync preceded by extra zeros is still found. A mismatching 0x0000 after 0xF872 counts as the first zero of a new attempt.
- R5: Cycles with `word_valid` low neither advance nor break matching or capture.
- R6: After a sync, the next two valid words become Pc and Pd. Both registers update together on the edge that accepts Pd, and `capture_valid` is high for exactly that one cycle. At all other times the two registers hold their values.
- R7: With no new sync, `detected` stays 1 through 4095 frame strobes after the last sync and drops to 0 on the 4096th.
- R8: Each sync reloads the full 4096-frame window. When a frame strobe coincides with the final sync word, the reload takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | Qualifies `word_in` for one subframe |
| word_in | input | 16 | Audio word of the current subframe |
| frame_strobe | input | 1 | One-clock pulse per stereo frame |
| detected | output | 1 | Sticky compressed-stream flag |
| burst_info_c | output | 16 | Captured Pc word |
| burst_info_d | output | 16 | Captured Pd word |
| capture_valid | output | 1 | One-clock pulse when Pc/Pd update |

## Verification
The matcher is exercised with five kinds of input:

- A sync with only three leading zeros, and a stray word after one zero. These separate exact matching from loose matching.
- A sync preceded by six zeros. This confirms that the zero run survives extra padding.
- A zero that breaks the sequence right after 0xF872. This shows the restart counts that zero as the first of a new run.
- Gaps with `word_valid` low, placed inside the pattern and between sync and Pc. These show that invalid cycles are transparent.

The timeout is tested at the 4095th and the 4096th strobe. It is also tested with a sync that coincides with a strobe and with a sync placed mid-window. Together these separate an off-by-one error from a missing reload.

// File: rtl/burst_sync_pkg.sv
package burst_sync_pkg;
    localparam int unsigned WORD_W = 16;
    localparam logic [WORD_W-1:0] SYNC_ZERO = 16'h0000;
    localparam logic [WORD_W-1:0] SYNC_MARK_A = 16'hF872;
    localparam logic [WORD_W-1:0] SYNC_MARK_B = 16'h4E1F;

    typedef enum logic [2:0] {
        M_IDLE, M_Z1, M_Z2, M_Z3, M_Z4, M_MARK_A
    } match_state_t;

    typedef enum logic {
        T_IDLE, T_HOLD
    } hold_state_t;

    typedef enum logic [1:0] {
        C_WAIT, C_PC, C_PD
    } cap_state_t;
endpackage

// File: rtl/burst_sync_matcher.sv
module burst_sync_matcher
    import burst_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic              sync_hit
);
    match_state_t state_q, state_d;
    logic is_zero;

    assign is_zero = (word_in == SYNC_ZERO);

    always_ff @(posedge clk) begin
        if (rst) state_q <= M_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (word_valid) begin
            unique case (state_q)
                M_IDLE:   state_d = is_zero ? M_Z1 : M_IDLE;
                M_Z1:     state_d = is_zero ? M_Z2 : M_IDLE;
                M_Z2:     state_d = is_zero ? M_Z3 : M_IDLE;
                M_Z3:     state_d = is_zero ? M_Z4 : M_IDLE;
                M_Z4: begin
                    if (is_zero)                      state_d = M_Z4;
                    else if (word_in == SYNC_MARK_A) state_d = M_MARK_A;
                    else                              state_d = M_IDLE;
                end
                M_MARK_A: state_d = is_zero ? M_Z1 : M_IDLE;
                default:  state_d = M_IDLE;
            endcase
        end
    end

    always_comb begin
        sync_hit = (state_q == M_MARK_A) && word_valid && (word_in == SYNC_MARK_B);
    end

    // R5: an invalid cycle leaves the match progress untouched
    p_gap_holds_state_r5: assert property (@(posedge clk) disable iff (rst)
        (!word_valid && !$past(rst)) |=> $stable(state_q));
endmodule

// File: rtl/burst_hold_timer.sv
module burst_hold_timer
    import burst_sync_pkg::*;
#(
    parameter int unsigned TIMEOUT_FRAMES = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_hit,
    input  logic frame_strobe,
    output logic detected
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_FRAMES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TIMEOUT_FRAMES);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    hold_state_t state_q, state_d;
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= T_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE: if (sync_hit) state_d = T_HOLD;
            T_HOLD: if (!sync_hit && frame_strobe && remain_q == CNT_ONE) state_d = T_IDLE;
            default: state_d = T_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                                   remain_q <= '0;
        else if (sync_hit)                         remain_q <= CNT_FULL;
        else if (state_q == T_HOLD && frame_strobe) remain_q <= remain_q - CNT_ONE;
    end

    always_comb begin
        detected = (state_q == T_HOLD);
    end

    // R2: the flag only rises as a result of a sync hit
    p_rise_on_hit_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(detected)) |-> $past(sync_hit));
    // R7: the flag only drops on a frame strobe
    p_fall_on_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(detected)) |-> $past(frame_strobe));
    // R8: a hit always leaves the flag set
    p_hit_sets_flag_r8: assert property (@(posedge clk) disable iff (rst)
        sync_hit |=> detected);
endmodule

// File: rtl/burst_info_capture.sv
module burst_info_capture
    import burst_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_hit,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] info_c,
    output logic [WORD_W-1:0] info_d,
    output logic              capture_valid
);
    cap_state_t state_q, state_d;
    logic [WORD_W-1:0] pc_hold_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= C_WAIT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (sync_hit) begin
            state_d = C_PC;
        end else if (word_valid) begin
            unique case (state_q)
                C_WAIT:  state_d = C_WAIT;
                C_PC:    state_d = C_PD;
                C_PD:    state_d = C_WAIT;
                default: state_d = C_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_hold_q     <= '0;
            info_c        <= '0;
            info_d        <= '0;
            capture_valid <= 1'b0;
        end else begin
            capture_valid <= 1'b0;
            if (!sync_hit && word_valid && state_q == C_PC) begin
                pc_hold_q <= word_in;
            end
            if (!sync_hit && word_valid && state_q == C_PD) begin
                info_c        <= pc_hold_q;
                info_d        <= word_in;
                capture_valid <= 1'b1;
            end
        end
    end

    // R6: the update pulse lasts a single cycle
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
        capture_valid |=> !capture_valid);
    // R6: registers change only together with the pulse
    p_regs_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!capture_valid && !$past(rst)) |-> ($stable(info_c) && $stable(info_d)));
    // R5: a capture needs an accepted word
    p_pulse_after_word_r5: assert property (@(posedge clk) disable iff (rst)
        (capture_valid && !$past(rst)) |-> $past(word_valid));
endmodule

// File: rtl/burst_sync_detector.sv
module burst_sync_detector
    import burst_sync_pkg::*;
#(
    parameter int unsigned TIMEOUT_FRAMES = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        word_valid,
    input  logic [15:0] word_in,
    input  logic        frame_strobe,
    output logic        detected,
    output logic [15:0] burst_info_c,
    output logic [15:0] burst_info_d,
    output logic        capture_valid
);
    logic sync_hit;

    burst_sync_matcher u_matcher (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .word_in    (word_in),
        .sync_hit   (sync_hit)
    );

    burst_hold_timer #(
        .TIMEOUT_FRAMES (TIMEOUT_FRAMES)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .sync_hit     (sync_hit),
        .frame_strobe (frame_strobe),
        .detected     (detected)
    );

    burst_info_capture u_capture (
        .clk           (clk),
        .rst           (rst),
        .sync_hit      (sync_hit),
        .word_valid    (word_valid),
        .word_in       (word_in),
        .info_c        (burst_info_c),
        .info_d        (burst_info_d),
        .capture_valid (capture_valid)
    );

    // R1: after a reset edge every output is cleared
    p_reset_clears_r1: assert property (@(posedge clk)
        $past(rst) |-> (!detected && !capture_valid && burst_info_c == '0 && burst_info_d == '0));
endmodule

// File: tb/tb_burst_sync_detector.sv
module tb_burst_sync_detector;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 31;
    // {valid, word, expected detected, expected capture_valid}
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b1, 16'h0000, 1'b0, 1'b0},
        {1'b1, 16'h0000, 1'b0, 1'b0},
        {1'b1, 16'h0000, 1'b0, 1'b0},
        {1'b1, 16'hF872, 1'b0, 1'b0},
        {1'b1, 16'h4E1F, 1'b0, 1'b0},
        {1'b1, 16'h0000, 1'b0, 1'b0},
        {1'b1, 16'h1234, 1'b0, 1'b0},
        {1'b1, 16'h0000, 1'b0, 1'b0},
        {1'b1, 16'h0000, 1'b0, 1'b0},
        {1'b1, 16'h0000, 1'b0, 1'b0},
        {1'b0, 16'hFFFF, 1'b0, 1'b0},
        {1'b1, 16'h0000, 1'b0, 1'b0},
        {1'b1, 16'h0000, 1'b0, 1'b0},
        {1'b1, 16'h0000, 1'b0, 1'b0},
        {1'b1, 16'hF872, 1'b0, 1'b0},
        {1'b1, 16'h4E1F, 1'b1, 1'b0},
        {1'b0, 16'h4E1F, 1'b1, 1'b0},
        {1'b1, 16'h0015, 1'b1, 1'b0},
        {1'b1, 16'h1000, 1'b1, 1'b1},
        {1'b1, 16'h0000, 1'b1, 1'b0},
        {1'b1, 16'h0000, 1'b1, 1'b0},
        {1'b1, 16'h0000, 1'b1, 1'b0},
        {1'b1, 16'h0000, 1'b1, 1'b0},
        {1'b1, 16'hF872, 1'b1, 1'b0},
        {1'b1, 16'h0000, 1'b1, 1'b0},
        {1'b1, 16'h0000, 1'b1, 1'b0},
        {1'b1, 16'h0000, 1'b1, 1'b0},
        {1'b1, 16'h0000, 1'b1, 1'b0},
        {1'b1, 16'hF872, 1'b1, 1'b0},
        {1'b1, 16'h4E1F, 1'b1, 1'b0},
        {1'b1, 16'h0003, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        word_valid;
    logic [15:0] word_in;
    logic        frame_strobe;
    logic        detected;
    logic [15:0] burst_info_c;
    logic [15:0] burst_info_d;
    logic        capture_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_sync_detector dut (
        .clk           (clk),
        .rst           (rst),
        .word_valid    (word_valid),
        .word_in       (word_in),
        .frame_strobe  (frame_strobe),
        .detected      (detected),
        .burst_info_c  (burst_info_c),
        .burst_info_d  (burst_info_d),
        .capture_valid (capture_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic step(input logic v, input logic [15:0] w, input logic s);
        word_valid   = v;
        word_in      = w;
        frame_strobe = s;
        @(negedge clk);
        word_valid   = 1'b0;
        word_in      = 16'h0000;
        frame_strobe = 1'b0;
    endtask

    task automatic send_sync(input logic strobe_last);
        for (int i = 0; i < 4; i++) step(1'b1, 16'h0000, 1'b0);
        step(1'b1, 16'hF872, 1'b0);
        step(1'b1, 16'h4E1F, strobe_last);
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        word_valid = 1'b0;
        word_in = 16'h0000;
        frame_strobe = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 detected", detected, 0);
        chk("R1 capture_valid", capture_valid, 0);
        chk("R1 pc", burst_info_c, 0);
        chk("R1 pd", burst_info_d, 0);

        // R2 R3 R4 R5 R6: vector walk
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][18], VEC[i][17:2], 1'b0);
            chk($sformatf("R2/R3/R4/R5 detected vec %0d", i), detected, VEC[i][1]);
            chk($sformatf("R6 capture_valid vec %0d", i), capture_valid, VEC[i][0]);
            if (i == 18) begin
                chk("R6 pc first", burst_info_c, 16'h0015);
                chk("R6 pd first", burst_info_d, 16'h1000);
            end
        end
        // Pc 0003 already sent; Pd completes the second capture
        step(1'b1, 16'h2000, 1'b0);
        chk("R6 capture_valid second", capture_valid, 1);
        chk("R6 pc second", burst_info_c, 16'h0003);
        chk("R6 pd second", burst_info_d, 16'h2000);
        step(1'b1, 16'h7777, 1'b0);
        chk("R6 pulse ends", capture_valid, 0);
        chk("R6 pc held", burst_info_c, 16'h0003);

        // R7: timeout boundary
        strobes(4095);
        chk("R7 held at 4095", detected, 1);
        strobes(1);
        chk("R7 cleared at 4096", detected, 0);
        strobes(3);
        chk("R7 stays clear", detected, 0);

        // R8: strobe coincident with sync, then a mid-window reload
        send_sync(1'b1);
        chk("R8 set with strobe", detected, 1);
        strobes(4095);
        chk("R8 reload beat strobe", detected, 1);
        send_sync(1'b0);
        strobes(4095);
        chk("R8 reload at 4095", detected, 1);
        strobes(1);
        chk("R8 clear after reload", detected, 0);

        // R1: reset during a pending capture
        send_sync(1'b0);
        step(1'b1, 16'hABCD, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid detected", detected, 0);
        chk("R1 mid pc", burst_info_c, 0);
        chk("R1 mid pd", burst_info_d, 0);
        step(1'b1, 16'h0001, 1'b0);
        chk("R1 capture aborted", capture_valid, 0);
        chk("R1 pd untouched", burst_info_d, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule